// File: doc/BRIEF.md
# Dedicated Pin Edge Interrupt Logic

This block serves three general-purpose pins that can also act as interrupt sources. Each pin has a private configuration register. It holds six switches: output enable, pull-up, interrupt enable, falling-edge select, input threshold select and open-drain drive. A shared data register holds the value each pin drives when it is an output. Every pin level passes through a two-stage synchronizer. A small per-pin state machine then tracks the level and raises a one-clock request on that pin's own interrupt line when it sees the selected edge.

Pad electrics are reduced to logic. The block drives `pad_oe`/`pad_out` and resolves the level it sees from its own drive, an external driver (`ext_drive`/`ext_level`) and the pull-up. A pin set as an output with its interrupt enabled can therefore raise its own request when software writes the matching data bit.

Each pin's tracker has four states:
- `LVL_LOW`: steady low.
- `LVL_ROSE`: just went high.
- `LVL_HIGH`: steady high.
- `LVL_FELL`: just went low.

The transitions are:
- `LVL_LOW` goes to `LVL_ROSE` on a high sample.
- `LVL_ROSE` goes to `LVL_HIGH` on a high sample, or to `LVL_FELL` on a low one.
- `LVL_HIGH` goes to `LVL_FELL` on a low sample.
- `LVL_FELL` goes to `LVL_LOW` on a low sample, or to `LVL_ROSE` on a high one.

The request is raised in `LVL_ROSE` when falling-edge select is clear, and in `LVL_FELL` when it is set. In both cases interrupt enable must be set.

Top module: `gpint_pins`

## Requirements
- R1: After reset every configuration register reads 0x02 (pull-up on, input), the data register holds 0, no pad is driven, no request is raised, and unconnected pins read high.
- R2: The configuration registers of pins 0, 1 and 2 sit at addresses 0x07, 0x08 and 0x09. Their bit fields are: [0] output enable, [1] pull-up, [2] interrupt enable, [3] falling-edge select, [4] threshold select, [5] open drain. Bits 7:6 read 0, and unmapped addresses read 0.
- R3: Address 0x00 is the data register. A write sets the output value of pin i from bit i. A read returns the synchronized pin levels in bits 2:0, with bits 7:3 zero.
- R4: `pad_out` equals the data bit. `pad_oe` is high when output enable is set, except when open drain is set and the data bit is 1.
- R5: The resolved level is chosen in this priority order: the data bit when the pad is driven; else `ext_level` when `ext_drive` is high; else 1 when open drain releases a 1 or the pull-up is on; else 0.
- R6: With falling-edge select clear, a low-to-high change of the resolved level raises the pin's request for exactly one cycle. The request appears in the third clock cycle after the change.
- R7: With falling-edge select set, a high-to-low change raises the request, and a low-to-high change does not.
- R8: With interrupt enable clear, no request is raised for any change.
- R9: Changing falling-edge select while the pin level is steady raises no request.
- R10: When a pin is an output with its interrupt enabled, a data-register write that makes the selected edge raises that pin's request.
- R11: Each pin has its own request line, and an edge on one pin raises only that pin's line.
- R12: The threshold-select bit is stored and read back, but it does not change edge detection.
- R13: `rd_data` loads on the clock edge where `bus_rd` is high and holds its value at all other times. A read in the same cycle as a write returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| ext_drive | input | 3 | External source is driving pin i |
| ext_level | input | 3 | Level the external source drives |
| pad_oe | output | 3 | Pad output enable per pin |
| pad_out | output | 3 | Pad output value per pin |
| pin_irq | output | 3 | One-cycle interrupt request per pin |

## Verification
The bench first flips the edge polarity while a pin rests high. A design that applies the polarity to only one of the two compared samples would fire a false request there. It then drives an output pin with interrupts enabled through data writes. Here a design that watched only the external input would stay silent, and one that fires on configuration writes would pulse too often.

Open-drain release, a floating pin without pull-up and unmapped addresses are each read back. This exposes a wrong priority in pin resolution or a stray field bit. Edges on single pins and on several pins at once show any crosstalk between request lines, and a request lasting two cycles.

// File: rtl/gpint_pkg.sv
package gpint_pkg;

    // Per-pin configuration; out_en lands on bit 0
    typedef struct packed {
        logic open_drain;
        logic ttl_sel;
        logic act_low;
        logic int_en;
        logic pull_up;
        logic out_en;
    } pin_cfg_t;

    localparam int CFG_W = $bits(pin_cfg_t);

    localparam pin_cfg_t CFG_RESET = '{
        open_drain: 1'b0,
        ttl_sel:    1'b0,
        act_low:    1'b0,
        int_en:     1'b0,
        pull_up:    1'b1,
        out_en:     1'b0
    };

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_ROSE = 2'b01,
        LVL_HIGH = 2'b11,
        LVL_FELL = 2'b10
    } lvl_state_t;

endpackage

// File: rtl/gpint_sync.sv
module gpint_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= {STAGES{RESET_VAL}};
        end else begin
            shreg <= {shreg[STAGES-2:0], d};
        end
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/gpint_pad.sv
module gpint_pad
    import gpint_pkg::*;
(
    input  pin_cfg_t cfg,
    input  logic     data_bit,
    input  logic     ext_drive,
    input  logic     ext_level,
    output logic     pad_oe,
    output logic     pad_out,
    output logic     level
);
    logic od_release;

    always_comb begin
        od_release = cfg.out_en & cfg.open_drain & data_bit;
        pad_oe     = cfg.out_en & ~od_release;
        pad_out    = data_bit;
        if (pad_oe) begin
            level = data_bit;
        end else if (ext_drive) begin
            level = ext_level;
        end else if (od_release || cfg.pull_up) begin
            level = 1'b1;
        end else begin
            level = 1'b0;
        end
    end
endmodule

// File: rtl/gpint_edge_fsm.sv
module gpint_edge_fsm
    import gpint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_sync,
    input  logic int_en,
    input  logic act_low,
    output logic irq
);
    lvl_state_t state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= LVL_HIGH;
        end else begin
            state <= state_nx;
        end
    end

    // next state from the raw synchronized level; polarity is not involved
    always_comb begin
        state_nx = state;
        unique case (state)
            LVL_LOW:  state_nx = lvl_sync ? LVL_ROSE : LVL_LOW;
            LVL_ROSE: state_nx = lvl_sync ? LVL_HIGH : LVL_FELL;
            LVL_HIGH: state_nx = lvl_sync ? LVL_HIGH : LVL_FELL;
            LVL_FELL: state_nx = lvl_sync ? LVL_ROSE : LVL_LOW;
            default:  state_nx = LVL_HIGH;
        endcase
    end

    // outputs: polarity selects which transition state requests service
    always_comb begin
        irq = 1'b0;
        unique case (state)
            LVL_ROSE: irq = int_en & ~act_low;
            LVL_FELL: irq = int_en & act_low;
            LVL_LOW,
            LVL_HIGH: irq = 1'b0;
            default:  irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpint_regs.sv
module gpint_regs
    import gpint_pkg::*;
#(
    parameter int NUM_PINS  = 3,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CFG_BASE  = 7,
    parameter int DATA_ADDR = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [NUM_PINS-1:0] sync_lvl,
    output pin_cfg_t            cfg_q [NUM_PINS],
    output logic [NUM_PINS-1:0] data_q,
    output logic [DATA_W-1:0]   rd_data
);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

    logic [DATA_W-1:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (bus_addr == DATA_A) begin
            rd_next[NUM_PINS-1:0] = sync_lvl;
        end
        for (int i = 0; i < NUM_PINS; i++) begin
            if (bus_addr == ADDR_W'(CFG_BASE + i)) begin
                rd_next[CFG_W-1:0] = cfg_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PINS; i++) begin
                cfg_q[i] <= CFG_RESET;
            end
            data_q  <= '0;
            rd_data <= '0;
        end else begin
            if (bus_wr) begin
                for (int i = 0; i < NUM_PINS; i++) begin
                    if (bus_addr == ADDR_W'(CFG_BASE + i)) begin
                        cfg_q[i] <= pin_cfg_t'(bus_wdata[CFG_W-1:0]);
                    end
                end
                if (bus_addr == DATA_A) begin
                    data_q <= bus_wdata[NUM_PINS-1:0];
                end
            end
            if (bus_rd) begin
                rd_data <= rd_next;
            end
        end
    end
endmodule

// File: rtl/gpint_pins.sv
module gpint_pins
    import gpint_pkg::*;
#(
    parameter int NUM_PINS    = 3,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int CFG_BASE    = 7,
    parameter int DATA_ADDR   = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NUM_PINS-1:0] ext_drive,
    input  logic [NUM_PINS-1:0] ext_level,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pin_irq
);
    pin_cfg_t            cfg_q [NUM_PINS];
    logic [NUM_PINS-1:0] data_q;
    logic [NUM_PINS-1:0] pin_lvl;
    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] int_en_v;
    logic [NUM_PINS-1:0] out_en_v;

    gpint_regs #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CFG_BASE (CFG_BASE),
        .DATA_ADDR(DATA_ADDR)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_wdata(bus_wdata),
        .sync_lvl (sync_lvl),
        .cfg_q    (cfg_q),
        .data_q   (data_q),
        .rd_data  (rd_data)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        gpint_pad u_pad (
            .cfg      (cfg_q[g]),
            .data_bit (data_q[g]),
            .ext_drive(ext_drive[g]),
            .ext_level(ext_level[g]),
            .pad_oe   (pad_oe[g]),
            .pad_out  (pad_out[g]),
            .level    (pin_lvl[g])
        );

        gpint_sync #(
            .STAGES   (SYNC_STAGES),
            .RESET_VAL(1'b1)
        ) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (pin_lvl[g]),
            .q    (sync_lvl[g])
        );

        gpint_edge_fsm u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .lvl_sync(sync_lvl[g]),
            .int_en  (cfg_q[g].int_en),
            .act_low (cfg_q[g].act_low),
            .irq     (pin_irq[g])
        );

        assign int_en_v[g] = cfg_q[g].int_en;
        assign out_en_v[g] = cfg_q[g].out_en;
    end
endmodule

// File: rtl/gpint_pins_chk.sv
module gpint_pins_chk #(
    parameter int NUM_PINS = 3,
    parameter int DATA_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] pin_irq,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] int_en_v,
    input logic [NUM_PINS-1:0] out_en_v,
    input logic [NUM_PINS-1:0] sync_lvl,
    input logic                bus_rd,
    input logic [DATA_W-1:0]   rd_data
);
    for (genvar g = 0; g < NUM_PINS; g++) begin : g_chk
        assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
            pin_irq[g] |-> int_en_v[g]);

        assert_irq_follows_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
            pin_irq[g] |-> ($past(sync_lvl[g]) != $past(sync_lvl[g], 2)));

        assert_drive_needs_out_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[g] |-> out_en_v[g]);
    end

    assert_read_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(rd_data));
endmodule

bind gpint_pins gpint_pins_chk #(
    .NUM_PINS(NUM_PINS),
    .DATA_W  (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_irq (pin_irq),
    .pad_oe  (pad_oe),
    .int_en_v(int_en_v),
    .out_en_v(out_en_v),
    .sync_lvl(sync_lvl),
    .bus_rd  (bus_rd),
    .rd_data (rd_data)
);

// File: tb/gpint_pins_test.sv
module gpint_pins_test;
    localparam int N = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n;
    logic [3:0]   bus_addr;
    logic         bus_wr, bus_rd;
    logic [7:0]   bus_wdata, rd_data;
    logic [N-1:0] ext_drive, ext_level, pad_oe, pad_out, pin_irq;

    gpint_pins uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .ext_drive(ext_drive), .ext_level(ext_level),
        .pad_oe(pad_oe), .pad_out(pad_out), .pin_irq(pin_irq)
    );

    int    n_chk = 0, n_bad = 0;
    string phase = "R1";
    int    m_cfg [N];
    int    m_data[N];
    int    hist  [N][4];
    int    m_rd;
    int    pulses[N];
    bit    done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int m_oe(int i);
        return ((m_cfg[i] & 1) != 0 && !((m_cfg[i] & 32) != 0 && m_data[i] == 1)) ? 1 : 0;
    endfunction

    function automatic int m_res(int i);
        if (m_oe(i) == 1) return m_data[i];
        if (ext_drive[i]) return int'(ext_level[i]);
        if ((m_cfg[i] & 1) != 0 && (m_cfg[i] & 32) != 0 && m_data[i] == 1) return 1;
        if ((m_cfg[i] & 2) != 0) return 1;
        return 0;
    endfunction

    // behavioural reference, advanced once per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_cfg[i] = 2; m_data[i] = 0;
                for (int k = 0; k < 4; k++) hist[i][k] = 1;
            end
            m_rd = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int k = 3; k > 0; k--) hist[i][k] = hist[i][k-1];
                hist[i][0] = m_res(i);
            end
            if (bus_rd) begin
                m_rd = 0;
                if (bus_addr == 0)
                    for (int i = 0; i < N; i++) m_rd += hist[i][2] << i;
                else if (bus_addr >= 7 && bus_addr <= 9)
                    m_rd = m_cfg[bus_addr - 7];
            end
            if (bus_wr) begin
                if (bus_addr >= 7 && bus_addr <= 9) m_cfg[bus_addr - 7] = bus_wdata & 8'h3F;
                if (bus_addr == 0)
                    for (int i = 0; i < N; i++) m_data[i] = (bus_wdata >> i) & 1;
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < N; i++) begin
                int e;
                bit al;
                al = (m_cfg[i] & 8) != 0;
                e  = 0;
                if ((m_cfg[i] & 4) != 0) begin
                    if (!al && hist[i][3] == 0 && hist[i][2] == 1) e = 1;
                    if ( al && hist[i][3] == 1 && hist[i][2] == 0) e = 1;
                end
                check(int'(pin_irq[i]) == e, phase, $sformatf("pin_irq[%0d]", i), int'(pin_irq[i]), e);
                check(int'(pad_oe[i]) == m_oe(i), "R4", $sformatf("pad_oe[%0d]", i), int'(pad_oe[i]), m_oe(i));
                check(int'(pad_out[i]) == m_data[i], "R4", $sformatf("pad_out[%0d]", i), int'(pad_out[i]), m_data[i]);
                pulses[i] += int'(pin_irq[i]);
            end
            check(int'(rd_data) == m_rd, "R13", "rd_data", int'(rd_data), m_rd);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input int a, input int d);
        tick(1);
        bus_addr = 4'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
        tick(1);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string req);
        tick(1);
        bus_addr = 4'(a); bus_rd = 1'b1;
        tick(1);
        bus_rd = 1'b0;
        check(int'(rd_data) == exp, req, $sformatf("read addr %0d", a), int'(rd_data), exp);
    endtask

    task automatic clr_pulses();
        for (int i = 0; i < N; i++) pulses[i] = 0;
    endtask

    task automatic exp_pulses(input string req, input int p0, input int p1, input int p2);
        tick(6);
        check(pulses[0] == p0, req, "pulses pin0", pulses[0], p0);
        check(pulses[1] == p1, req, "pulses pin1", pulses[1], p1);
        check(pulses[2] == p2, req, "pulses pin2", pulses[2], p2);
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
        ext_drive = '0; ext_level = '0;
        clr_pulses();
        tick(4);
        rst_n = 1'b1;
        tick(2);

        // R1: reset state
        phase = "R1";
        check(pad_oe == 3'b000, "R1", "pad_oe after reset", int'(pad_oe), 0);
        check(pin_irq == 3'b000, "R1", "pin_irq after reset", int'(pin_irq), 0);
        rd_chk(7, 8'h02, "R1");
        rd_chk(8, 8'h02, "R1");
        rd_chk(9, 8'h02, "R1");
        rd_chk(0, 8'h07, "R1");

        // R2: field layout, reserved bits, unmapped address
        phase = "R2";
        wr(8, 8'hFF);
        rd_chk(8, 8'h3F, "R2");
        wr(8, 8'h02);
        rd_chk(10, 8'h00, "R2");
        tick(6);

        // R6: rising edge, active high
        phase = "R6";
        wr(7, 8'h06);
        ext_drive[0] = 1'b1; ext_level[0] = 1'b0;
        tick(6);
        clr_pulses();
        ext_level[0] = 1'b1;
        exp_pulses("R6", 1, 0, 0);

        // R7: falling edge selected
        phase = "R7";
        wr(8, 8'h0E);
        tick(4);
        clr_pulses();
        ext_drive[1] = 1'b1; ext_level[1] = 1'b0;
        exp_pulses("R7", 0, 1, 0);
        clr_pulses();
        ext_drive[1] = 1'b0;
        exp_pulses("R7", 0, 0, 0);

        // R8: interrupt disabled
        phase = "R8";
        clr_pulses();
        ext_drive[2] = 1'b1; ext_level[2] = 1'b0;
        tick(5);
        ext_level[2] = 1'b1;
        exp_pulses("R8", 0, 0, 0);
        ext_drive[2] = 1'b0;

        // R9: polarity flips on a steady pin
        phase = "R9";
        tick(4);
        clr_pulses();
        wr(7, 8'h0E);
        tick(3);
        wr(7, 8'h06);
        tick(3);
        wr(7, 8'h0E);
        exp_pulses("R9", 0, 0, 0);
        wr(7, 8'h06);

        // R10: self-triggered by a data write on an output pin
        phase = "R10";
        tick(4);
        clr_pulses();
        wr(9, 8'h05);
        tick(5);
        check(pad_oe[2] == 1'b1, "R10", "pad_oe[2] output", int'(pad_oe[2]), 1);
        exp_pulses("R10", 0, 0, 0);
        clr_pulses();
        wr(0, 8'h04);
        exp_pulses("R10", 0, 0, 1);
        wr(0, 8'h00);
        wr(9, 8'h02);
        tick(5);

        // R5 / R3: open-drain release, floating pin, data readback
        phase = "R5";
        wr(8, 8'h21);
        wr(0, 8'h02);
        tick(5);
        check(pad_oe[1] == 1'b0, "R5", "open drain released", int'(pad_oe[1]), 0);
        rd_chk(0, 8'h07, "R5");
        wr(0, 8'h00);
        tick(5);
        rd_chk(0, 8'h05, "R3");
        wr(7, 8'h00);
        ext_drive[0] = 1'b0;
        tick(5);
        rd_chk(0, 8'h04, "R5");

        // R11: independent lines
        phase = "R11";
        wr(7, 8'h06); wr(8, 8'h06); wr(9, 8'h06);
        ext_drive = 3'b111; ext_level = 3'b000;
        tick(6);
        clr_pulses();
        ext_level = 3'b001;
        exp_pulses("R11", 1, 0, 0);
        clr_pulses();
        ext_level = 3'b111;
        exp_pulses("R11", 0, 1, 1);

        // R12: threshold select does not affect detection
        phase = "R12";
        ext_level = 3'b000;
        wr(7, 8'h16);
        tick(6);
        rd_chk(7, 8'h16, "R12");
        clr_pulses();
        ext_level = 3'b001;
        exp_pulses("R12", 1, 0, 0);

        tick(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule